// File: doc/BRIEF.md
# CPU Reset and Exception Sequencer

This block sits next to a pipelined 32-bit processor core. It controls how the core leaves reset and how it takes synchronous hardware exceptions. Two active-high requests can start a reset: a system request and a debug request. A request counts only after it has been held for a minimum number of consecutive cycles. While reset is in force, the block flushes the pipeline and points fetch at the vector base. It also loads the machine status register with a value built from per-field configuration parameters. The `core_rst_o` level tells the owners of the exception address, floating-point status, process ID, zone protection and TLB index registers, and of the load/store reservation, to clear them.

Outside reset, the execute stage reports exception cause flags along with its program counter and two context bits. One bit says whether the instruction followed an immediate prefix. The other says whether it sits in a branch delay slot, and a third input says whether that branch had a prefix. When an exception is taken, the block does four things in the same cycle: it flushes the pipeline, so the execute-stage instruction does not complete; it redirects fetch to the base plus 0x20; it writes general register 17 with a return address that re-executes the faulting sequence; and it latches the cause and sets the in-progress bit. The in-progress bit masks further exceptions until software clears it.

Top module: `cpu_rst_exc_seq`

## Requirements
- R1: Each reset request (`sys_rst_req_i`, `dbg_rst_req_i`) is filtered on its own. `core_rst_o` rises only after a request has been sampled high on MIN_HOLD (default 16) consecutive rising edges. A shorter pulse has no effect.
- R2: Once reset is in force, it stays in force while the request that caused it stays high. `core_rst_o` falls after the first rising edge that samples that request low.
- R3: While `core_rst_o` is high, the outputs hold these values: `flush_o`=1, `redir_vld_o`=1, `redir_addr_o`=VEC_BASE and `r17_we_o`=0. Exception inputs are ignored.
- R4: Each cycle in reset loads the status register `msr_o` with the configured reset value. The fields sit at these bits: interrupt enable 2, break-in-progress 4, instruction cache enable 6, data cache enable 8, exception enable 9, exception-in-progress 10. All other bits are 0. The same cycles load `esr_o` with 0.
- R5: An exception is taken in a cycle when all of these hold: `ex_valid_i` is 1, an enabled cause bit is set, `msr_o[9]` is 1 and `msr_o[10]` is 0. In that same cycle, `flush_o`, `redir_vld_o` and `r17_we_o` are 1, and `redir_addr_o` is VEC_BASE+0x20.
- R6: For an instruction that has no prefix and is not in a delay slot, `r17_data_o` equals `ex_pc_i`.
- R7: When `ex_after_imm_i` is 1 and the instruction is not in a delay slot, `r17_data_o` is `ex_pc_i`-4.
- R8: When `ex_in_dslot_i` is 1, `r17_data_o` is `ex_pc_i`-4. If `br_after_imm_i` is also 1, it is `ex_pc_i`-8.
- R9: The cause bits of `ex_cause_i` are: [0] illegal instruction, [1] instruction bus error, [2] data bus error, [3] unaligned access, [4] divide by zero. The priority is bit 1 > bit 0 > bit 3 > bit 2 > bit 4. The cycle after a take, `esr_o[4:0]` holds the code of the chosen cause: illegal 1, instruction bus 2, data bus 3, unaligned 4, divide 5. The upper bits are 0.
- R10: The cycle after a take, `msr_o[10]` is 1. While it is 1, no exception is taken. Asserting `eip_clr_i` clears it on the next cycle.
- R11: When HAS_DIV is 0, cause bit 4 is ignored.
- R12: While `ex_valid_i` is 0, no exception is taken, whatever the cause bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_req_i | input | 1 | System reset request, active high |
| dbg_rst_req_i | input | 1 | Debug reset request, active high |
| ex_valid_i | input | 1 | Execute stage holds a valid instruction |
| ex_cause_i | input | 5 | Exception cause flags |
| ex_pc_i | input | 32 | Execute-stage program counter |
| ex_after_imm_i | input | 1 | Instruction follows an immediate prefix |
| ex_in_dslot_i | input | 1 | Instruction sits in a branch delay slot |
| br_after_imm_i | input | 1 | The owning branch follows an immediate prefix |
| eip_clr_i | input | 1 | Software clear of the in-progress bit |
| core_rst_o | output | 1 | Reset in force; also clears the special registers and the reservation |
| flush_o | output | 1 | Pipeline flush |
| redir_vld_o | output | 1 | Fetch redirect valid |
| redir_addr_o | output | 32 | Fetch redirect target |
| r17_we_o | output | 1 | Write enable for general register 17 |
| r17_data_o | output | 32 | Return address for general register 17 |
| msr_o | output | 32 | Machine status register |
| esr_o | output | 32 | Exception status register |

## Verification
Some properties are checked on every cycle. A request that is sampled low always drops its filter's output. A reset cycle never writes register 17 and always flushes. A register 17 write always comes with a flush to the exception vector. No exception is taken while the in-progress bit is set. A take always leaves a nonzero cause code with the in-progress bit set. Other behaviours can only be shown by the bench's scenarios: the exact cycle on which a 16-cycle hold turns into reset, the rejection of a 15-cycle pulse, the per-field status reset value, the return-address adjustments for prefix and delay-slot cases, the cause priority, and the ignoring of the divide cause when no divider is present.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int XLEN    = 32;
    localparam int INSN_B  = 4;
    localparam int NCAUSE  = 5;
    localparam int EXC_OFS = 32'h20;

    // status register field positions
    localparam int MSR_IE  = 2;
    localparam int MSR_BIP = 4;
    localparam int MSR_ICE = 6;
    localparam int MSR_DCE = 8;
    localparam int MSR_EE  = 9;
    localparam int MSR_EIP = 10;

    // cause flag positions
    localparam int CB_ILL  = 0;
    localparam int CB_IBUS = 1;
    localparam int CB_DBUS = 2;
    localparam int CB_UNAL = 3;
    localparam int CB_DIV  = 4;

    typedef enum logic [4:0] {
        EC_NONE = 5'd0,
        EC_ILL  = 5'd1,
        EC_IBUS = 5'd2,
        EC_DBUS = 5'd3,
        EC_UNAL = 5'd4,
        EC_DIV  = 5'd5
    } exc_code_e;

    typedef struct packed {
        logic after_imm;
        logic in_dslot;
        logic br_after_imm;
    } ex_ctx_t;

    function automatic logic [XLEN-1:0] msr_reset_val(
        input bit ie, input bit bip, input bit ice,
        input bit dce, input bit ee, input bit eip);
        logic [XLEN-1:0] v;
        v          = '0;
        v[MSR_IE]  = ie;
        v[MSR_BIP] = bip;
        v[MSR_ICE] = ice;
        v[MSR_DCE] = dce;
        v[MSR_EE]  = ee;
        v[MSR_EIP] = eip;
        return v;
    endfunction

endpackage

// File: rtl/rxs_rst_filter.sv
module rxs_rst_filter #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic req_i,
    output logic act_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] CMAX = CW'(HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!req_i)
            cnt_q <= '0;
        else if (cnt_q != CMAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign act_o = (cnt_q == CMAX);

    // R1
    req_low_drops_chk: assert property (@(posedge clk) !req_i |=> !act_o);

endmodule

// File: rtl/rxs_cause_pick.sv
module rxs_cause_pick
    import rxs_pkg::*;
#(
    parameter bit HAS_DIV = 1'b1
) (
    input  logic [NCAUSE-1:0] cause_i,
    output logic              any_o,
    output exc_code_e         code_o
);
    logic [NCAUSE-1:0] en_mask;
    logic [NCAUSE-1:0] eff;

    generate
        if (HAS_DIV) begin : g_div
            assign en_mask = '1;
        end else begin : g_nodiv
            assign en_mask = ~(NCAUSE'(1) << CB_DIV);
        end
    endgenerate

    assign eff   = cause_i & en_mask;
    assign any_o = |eff;

    always_comb begin
        if (eff[CB_IBUS])      code_o = EC_IBUS;
        else if (eff[CB_ILL])  code_o = EC_ILL;
        else if (eff[CB_UNAL]) code_o = EC_UNAL;
        else if (eff[CB_DBUS]) code_o = EC_DBUS;
        else if (eff[CB_DIV])  code_o = EC_DIV;
        else                   code_o = EC_NONE;
    end

endmodule

// File: rtl/rxs_ret_addr.sv
module rxs_ret_addr
    import rxs_pkg::*;
(
    input  logic [XLEN-1:0] pc_i,
    input  ex_ctx_t         ctx_i,
    output logic [XLEN-1:0] ret_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);

    logic [XLEN-1:0] back;

    always_comb begin
        if (ctx_i.in_dslot)
            back = ctx_i.br_after_imm ? (STEP + STEP) : STEP;
        else
            back = ctx_i.after_imm ? STEP : '0;
        ret_o = pc_i - back;
    end

endmodule

// File: rtl/cpu_rst_exc_seq.sv
module cpu_rst_exc_seq
    import rxs_pkg::*;
#(
    parameter logic [31:0] VEC_BASE = 32'h0000_0000,
    parameter int          MIN_HOLD = 16,
    parameter bit          HAS_DIV  = 1'b1,
    parameter bit          RST_IE   = 1'b0,
    parameter bit          RST_BIP  = 1'b0,
    parameter bit          RST_ICE  = 1'b0,
    parameter bit          RST_DCE  = 1'b0,
    parameter bit          RST_EE   = 1'b1,
    parameter bit          RST_EIP  = 1'b0
) (
    input  logic        clk,
    input  logic        sys_rst_req_i,
    input  logic        dbg_rst_req_i,
    input  logic        ex_valid_i,
    input  logic [4:0]  ex_cause_i,
    input  logic [31:0] ex_pc_i,
    input  logic        ex_after_imm_i,
    input  logic        ex_in_dslot_i,
    input  logic        br_after_imm_i,
    input  logic        eip_clr_i,
    output logic        core_rst_o,
    output logic        flush_o,
    output logic        redir_vld_o,
    output logic [31:0] redir_addr_o,
    output logic        r17_we_o,
    output logic [31:0] r17_data_o,
    output logic [31:0] msr_o,
    output logic [31:0] esr_o
);
    localparam int NREQ = 2;
    localparam logic [XLEN-1:0] RST_MSR =
        msr_reset_val(RST_IE, RST_BIP, RST_ICE, RST_DCE, RST_EE, RST_EIP);
    localparam logic [XLEN-1:0] EXC_VEC = VEC_BASE + XLEN'(EXC_OFS);

    logic [NREQ-1:0] req_vec;
    logic [NREQ-1:0] act_vec;

    assign req_vec = {dbg_rst_req_i, sys_rst_req_i};

    generate
        for (genvar i = 0; i < NREQ; i++) begin : g_filt
            rxs_rst_filter #(.HOLD(MIN_HOLD)) u_filt (
                .clk   (clk),
                .req_i (req_vec[i]),
                .act_o (act_vec[i])
            );
        end
    endgenerate

    assign core_rst_o = |act_vec;

    logic      cause_any;
    exc_code_e cause_code;

    rxs_cause_pick #(.HAS_DIV(HAS_DIV)) u_pick (
        .cause_i (ex_cause_i),
        .any_o   (cause_any),
        .code_o  (cause_code)
    );

    ex_ctx_t         ctx;
    logic [XLEN-1:0] ret_addr;

    assign ctx = '{after_imm: ex_after_imm_i, in_dslot: ex_in_dslot_i,
                   br_after_imm: br_after_imm_i};

    rxs_ret_addr u_ret (
        .pc_i  (ex_pc_i),
        .ctx_i (ctx),
        .ret_o (ret_addr)
    );

    logic [XLEN-1:0] msr_q;
    logic [4:0]      esr_q;
    logic            take;

    assign take = !core_rst_o && ex_valid_i && cause_any
                  && msr_q[MSR_EE] && !msr_q[MSR_EIP];

    always_ff @(posedge clk) begin
        if (core_rst_o) begin
            msr_q <= RST_MSR;
            esr_q <= '0;
        end else if (take) begin
            msr_q[MSR_EIP] <= 1'b1;
            esr_q          <= cause_code;
        end else if (eip_clr_i) begin
            msr_q[MSR_EIP] <= 1'b0;
        end
    end

    assign flush_o      = core_rst_o || take;
    assign redir_vld_o  = flush_o;
    assign redir_addr_o = core_rst_o ? VEC_BASE : EXC_VEC;
    assign r17_we_o     = take;
    assign r17_data_o   = ret_addr;
    assign msr_o        = msr_q;
    assign esr_o        = {{(XLEN-5){1'b0}}, esr_q};

    // R3
    rst_quiet_chk: assert property (@(posedge clk)
        core_rst_o |-> (flush_o && !r17_we_o));

    // R5
    r17_with_vector_chk: assert property (@(posedge clk) disable iff (core_rst_o)
        r17_we_o |-> (flush_o && redir_vld_o && redir_addr_o == EXC_VEC));

    // R10
    eip_mask_chk: assert property (@(posedge clk) disable iff (core_rst_o)
        msr_o[MSR_EIP] |-> !r17_we_o);

    // R9
    esr_code_chk: assert property (@(posedge clk) disable iff (core_rst_o)
        r17_we_o |=> (esr_o[4:0] != 5'd0 && msr_o[MSR_EIP]));

    // R4
    msr_reset_chk: assert property (@(posedge clk)
        $fell(core_rst_o) |-> (msr_o == RST_MSR && esr_o == '0));

endmodule

// File: tb/sim_cpu_rst_exc_seq.sv
module sim_cpu_rst_exc_seq;

    localparam logic [31:0] BASE = 32'h0000_2000;
    localparam logic [31:0] EXP_RST_MSR = 32'h0000_0244; // IE(2), ICE(6), EE(9)

    logic        clk = 1'b0;
    logic        sreq = 1'b0, dreq = 1'b0, vld = 1'b0;
    logic [4:0]  cause = '0;
    logic [31:0] pc = '0;
    logic        aimm = 1'b0, ds = 1'b0, bimm = 1'b0, clr = 1'b0;
    logic        core_rst, flush, rvld, we;
    logic [31:0] raddr, rdata, msr, esr;

    always #10 clk = ~clk;

    cpu_rst_exc_seq #(
        .VEC_BASE(BASE), .MIN_HOLD(16), .HAS_DIV(1'b0),
        .RST_IE(1'b1), .RST_BIP(1'b0), .RST_ICE(1'b1),
        .RST_DCE(1'b0), .RST_EE(1'b1), .RST_EIP(1'b0)
    ) u0 (
        .clk(clk), .sys_rst_req_i(sreq), .dbg_rst_req_i(dreq),
        .ex_valid_i(vld), .ex_cause_i(cause), .ex_pc_i(pc),
        .ex_after_imm_i(aimm), .ex_in_dslot_i(ds), .br_after_imm_i(bimm),
        .eip_clr_i(clr), .core_rst_o(core_rst), .flush_o(flush),
        .redir_vld_o(rvld), .redir_addr_o(raddr), .r17_we_o(we),
        .r17_data_o(rdata), .msr_o(msr), .esr_o(esr)
    );

    typedef struct packed {
        logic        rst;
        logic        flush;
        logic        vld;
        logic [31:0] addr;
        logic        we;
        logic [31:0] data;
        logic        chk_spr;
        logic [31:0] msr;
        logic [31:0] esr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;

    // reference model state
    int          m_cs = 0, m_cd = 0;
    logic [31:0] m_msr = '0, m_esr = '0;
    bit          m_known = 1'b0;

    function automatic logic [4:0] pick(input logic [4:0] c);
        if (c[1])      return 5'd2;
        else if (c[0]) return 5'd1;
        else if (c[3]) return 5'd4;
        else if (c[2]) return 5'd3;
        else           return 5'd0;   // divider absent: bit 4 ignored (R11)
    endfunction

    task automatic step(input logic s, input logic d, input logic v,
                        input logic [4:0] c, input logic [31:0] p,
                        input logic ai, input logic dsl, input logic bi,
                        input logic cl, input string tag);
        exp_t e;
        logic take;
        logic [4:0] code;
        @(negedge clk);
        sreq = s; dreq = d; vld = v; cause = c; pc = p;
        aimm = ai; ds = dsl; bimm = bi; clr = cl;
        e = '0;
        e.rst = (m_cs >= 16) || (m_cd >= 16);
        code = pick(c);
        take = !e.rst && v && (code != 5'd0) && m_msr[9] && !m_msr[10];
        e.flush = e.rst || take;
        e.vld   = e.flush;
        e.addr  = e.rst ? BASE : BASE + 32'h20;
        e.we    = take;
        if (dsl) e.data = p - (bi ? 32'd8 : 32'd4);
        else     e.data = p - (ai ? 32'd4 : 32'd0);
        e.chk_spr = m_known;
        e.msr = m_msr;
        e.esr = m_esr;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (e.rst) begin
            m_msr = EXP_RST_MSR; m_esr = '0; m_known = 1'b1;
        end else if (take) begin
            m_msr[10] = 1'b1; m_esr = {27'd0, code};
        end else if (cl) begin
            m_msr[10] = 1'b0;
        end
        m_cs = s ? ((m_cs < 16) ? m_cs + 1 : 16) : 0;
        m_cd = d ? ((m_cd < 16) ? m_cd + 1 : 16) : 0;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 5'd0, 32'h0, 0, 0, 0, 0, tag);
    endtask

    task automatic exc(input logic [4:0] c, input logic [31:0] p,
                       input logic ai, input logic dsl, input logic bi,
                       input string tag);
        step(0, 0, 1, c, p, ai, dsl, bi, 0, tag);
    endtask

    // monitor: compare design outputs against the queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                bit    bad;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                bad = (core_rst !== e.rst) || (flush !== e.flush) || (rvld !== e.vld)
                   || (e.vld && raddr !== e.addr) || (we !== e.we)
                   || (e.we && rdata !== e.data)
                   || (e.chk_spr && (msr !== e.msr || esr !== e.esr));
                n_chk++;
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: got rst=%b fl=%b v=%b a=%h we=%b d=%h msr=%h esr=%h exp rst=%b fl=%b v=%b a=%h we=%b d=%h msr=%h esr=%h",
                        t, core_rst, flush, rvld, raddr, we, rdata, msr, esr,
                        e.rst, e.flush, e.vld, e.addr, e.we, e.data, e.msr, e.esr);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle("R1 idle");
        idle("R1 idle");
        for (int i = 0; i < 15; i++) step(1, 0, 0, 5'd0, 0, 0, 0, 0, 0, "R1 short system pulse");
        idle("R1 after short pulse");
        for (int i = 0; i < 20; i++) step(1, 0, 1, 5'd1, 32'h40, 0, 0, 0, 0, "R2 R3 system hold");
        idle("R2 release");
        idle("R4 reset value");
        exc(5'b00001, 32'h100, 0, 0, 0, "R5 R6 illegal plain");
        idle("R9 R10 esr and in-progress");
        exc(5'b00100, 32'h200, 0, 0, 0, "R10 masked while in progress");
        step(0, 0, 0, 5'd0, 0, 0, 0, 0, 1, "R10 clear");
        idle("R10 cleared");
        exc(5'b01110, 32'h300, 1, 0, 0, "R7 R9 priority after prefix");
        step(0, 0, 0, 5'd0, 0, 0, 0, 0, 1, "R9 ibus code");
        exc(5'b01100, 32'h400, 0, 1, 0, "R8 R9 delay slot unaligned");
        step(0, 0, 0, 5'd0, 0, 0, 0, 0, 1, "R9 unaligned code");
        exc(5'b00100, 32'h500, 1, 1, 1, "R8 delay slot branch prefix");
        step(0, 0, 0, 5'd0, 0, 0, 0, 0, 1, "R9 dbus code");
        idle("R10 cleared again");
        exc(5'b10000, 32'h600, 0, 0, 0, "R11 divide ignored");
        step(0, 0, 0, 5'b00011, 32'h700, 0, 0, 0, 0, "R12 no valid");
        idle("R12 state unchanged");
        exc(5'b00010, 32'h800, 0, 0, 0, "R5 ibus plain");
        idle("R10 set before debug reset");
        for (int i = 0; i < 15; i++) step(0, 1, 0, 5'd0, 0, 0, 0, 0, 0, "R1 short debug pulse");
        idle("R1 after short debug pulse");
        for (int i = 0; i < 18; i++) step(0, 1, 0, 5'd0, 0, 0, 0, 0, 0, "R1 R3 debug hold");
        idle("R2 debug release");
        idle("R4 reset value after debug");
        exc(5'b01000, 32'h900, 0, 0, 0, "R5 R9 unaligned after reset");
        idle("R9 unaligned code");
        idle("R9 final");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule